// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character at a time into a framed bit stream on a single output line. Each frame is a low start bit, then the character's data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. When nothing is being sent the line rests high. The data length, parity mode and stop-bit count are chosen at run time through configuration inputs, which gives 30 frame formats. The configuration is captured together with the character, so software may change it while a frame is still going out.

Bit timing comes from outside the block. In asynchronous mode an oversampling tick input is counted, and every sixteenth tick ends a bit. In synchronous mode an external serial clock, sampled in the system clock domain, moves the line forward on the edge chosen by a polarity input. On the parallel side a valid/ready handshake fills a single holding slot. This lets a new character be queued during the final stop bit, so that frames follow each other with no idle gap.

Top module: `frame_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `txd` is 1. Right after reset `in_ready` is 1.
- R2: A frame begins with a single 0 start bit, followed by the data bits of `in_data` with bit 0 first. The number of data bits is set by `cfg_len`: code 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8 and 4 gives 9. Codes 5 to 7 give 9.
- R3: `cfg_par` selects the parity: 2'b00 and 2'b11 mean no parity bit, 2'b01 means even and 2'b10 means odd. When parity is enabled, one parity bit follows the last data bit. Even parity makes the count of ones over the configured data bits plus the parity bit even, and odd parity makes it odd.
- R4: The frame ends with one high stop bit when `cfg_stop2` is 0 and with two when it is 1.
- R5: With `sync_mode`=0, `os_tick` pulses are counted starting from reset, but only in cycles where `sync_mode` is 0. Every 16th counted pulse is a bit boundary. `txd` takes its new value in the clock cycle after the boundary pulse and does not change in any other cycle.
- R6: With `sync_mode`=1, `sclk` is registered once. A bit boundary is a change of `sclk` from the registered value: a 0-to-1 change when `sclk_pol`=0 and a 1-to-0 change when `sclk_pol`=1. In this mode `os_tick` has no effect.
- R7: `in_ready` is 1 only when the holding slot is empty and the line is either idle or sending the final stop bit of its frame. A character is accepted in a cycle where `in_valid` and `in_ready` are both 1.
- R8: If a character is waiting, or is accepted in the same cycle as the boundary that ends the final stop bit, its start bit follows that stop bit directly, with no idle bit in between.
- R9: The format inputs are captured in the cycle a character is accepted. Changing them afterwards has no effect on that character's frame.
- R10: A character accepted while the line is idle starts its frame at the next bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 selects serial-clock timing, 0 selects tick timing |
| os_tick | input | 1 | Oversampling tick, 16 per bit in asynchronous mode |
| sclk | input | 1 | External serial clock for synchronous mode |
| sclk_pol | input | 1 | 0: line moves on rising sclk, 1: on falling sclk |
| cfg_len | input | 3 | Data-length code (5 to 9 bits) |
| cfg_par | input | 2 | Parity mode code |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| in_valid | input | 1 | Character offered |
| in_data | input | 9 | Character, bit 0 sent first |
| in_ready | output | 1 | Holding slot can take a character |
| txd | output | 1 | Serial line, high when idle |

## Verification
The assertions assume that every input changes in step with `clk`, and that `sclk` holds each level for at least one full clock so that each of its edges shows up as one registered change. They also assume that a reset is long enough to load the current `sclk` level into its sampling register. The bench changes all inputs half a cycle away from the active edge. It toggles `sclk` every one or two clocks and holds `in_valid` and `in_data` until a character is accepted. It also varies the format inputs and the mode inputs that are not in use on every cycle, including the reserved parity and length codes, so that mid-frame changes and ignored inputs are exercised throughout.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;

    function automatic logic par_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/frame_tx_pace.sv
module frame_tx_pace #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic os_tick,
    input  logic sclk,
    input  logic sclk_pol,
    output logic step_o
);
    localparam int CNT_W = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OS_RATE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk_prev;
    } pace_t;

    pace_t st_d, st_q;
    logic  launch;
    logic  tick_end;

    always_comb begin
        st_d     = st_q;
        launch   = sclk_pol ? (st_q.sclk_prev & ~sclk) : (~st_q.sclk_prev & sclk);
        tick_end = os_tick && (st_q.cnt == CNT_TOP);
        step_o   = sync_mode ? launch : tick_end;
        if (!sync_mode && os_tick) begin
            st_d.cnt = tick_end ? '0 : st_q.cnt + 1'b1;
        end
        st_d.sclk_prev = sclk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt       <= '0;
            st_q.sclk_prev <= sclk;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: tick mode never steps without a tick
    p_tick_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !os_tick) |-> !step_o);

    // R6: serial-clock mode never steps while sclk holds its level
    p_sclk_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && $stable(sclk)) |-> !step_o);

endmodule

// File: rtl/frame_tx_build.sv
module frame_tx_build
    import frame_tx_pkg::*;
#(
    parameter int MIN_DATA = 5,
    parameter int MAX_DATA = 9,
    parameter int FRAME_W  = MAX_DATA + 4,
    parameter int LEN_W    = $clog2(FRAME_W + 1)
) (
    input  logic [MAX_DATA-1:0] data_i,
    input  logic [2:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_stop2,
    output logic [FRAME_W-1:0]  frame_o,
    output logic [LEN_W-1:0]    len_o
);
    logic [LEN_W-1:0] nbits;
    logic             ones;
    logic             pen;

    always_comb begin
        if (int'(cfg_len) > MAX_DATA - MIN_DATA) begin
            nbits = LEN_W'(MAX_DATA);
        end else begin
            nbits = LEN_W'(MIN_DATA + int'(cfg_len));
        end
        pen     = par_on(cfg_par);
        ones    = 1'b0;
        frame_o = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(nbits)) begin
                frame_o[1+i] = data_i[i];
                ones         = ones ^ data_i[i];
            end
        end
        if (pen) begin
            frame_o[int'(nbits) + 1] = (cfg_par == PAR_ODD) ? ~ones : ones;
        end
        len_o = LEN_W'(int'(nbits) + 2 + int'(pen) + int'(cfg_stop2));
    end

endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift #(
    parameter int FRAME_W = 13,
    parameter int LEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FRAME_W-1:0] new_frame,
    input  logic [LEN_W-1:0]   new_len,
    output logic               txd_o
);
    typedef struct packed {
        logic               busy;
        logic [LEN_W-1:0]   idx;
        logic [LEN_W-1:0]   len;
        logic [FRAME_W-1:0] frame;
        logic               txd;
        logic               pend_v;
        logic [FRAME_W-1:0] pend_frame;
        logic [LEN_W-1:0]   pend_len;
    } shift_t;

    shift_t st_d, st_q;
    logic   last_bit;
    logic   accept;
    logic   take_new;

    always_comb begin
        st_d     = st_q;
        last_bit = st_q.busy && (st_q.idx == st_q.len - 1'b1);
        in_ready = !st_q.pend_v && (!st_q.busy || last_bit);
        accept   = in_valid && in_ready;
        take_new = accept;
        if (step_i) begin
            if (st_q.busy && !last_bit) begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.txd = st_q.frame[st_q.idx + 1'b1];
            end else if (st_q.pend_v) begin
                st_d.busy   = 1'b1;
                st_d.idx    = '0;
                st_d.frame  = st_q.pend_frame;
                st_d.len    = st_q.pend_len;
                st_d.txd    = st_q.pend_frame[0];
                st_d.pend_v = 1'b0;
            end else if (accept) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.frame = new_frame;
                st_d.len   = new_len;
                st_d.txd   = new_frame[0];
                take_new   = 1'b0;
            end else begin
                st_d.busy = 1'b0;
                st_d.txd  = 1'b1;
            end
        end
        if (take_new) begin
            st_d.pend_v     = 1'b1;
            st_d.pend_frame = new_frame;
            st_d.pend_len   = new_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.txd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_o = st_q.txd;

    // R1: idle line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> st_q.txd);

    // R2: every frame opens with a low bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> !st_q.txd);

    // R5: line only moves on a bit boundary
    p_quiet_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(st_q.txd));

    // R7: a filled slot blocks the handshake
    p_slot_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_v |-> !in_ready);

    // R8: an accepted character not launched at once waits in the slot
    p_accept_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !step_i) |=> st_q.pend_v);

endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
    parameter int MIN_DATA = 5,
    parameter int MAX_DATA = 9,
    parameter int OS_RATE  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_mode,
    input  logic                os_tick,
    input  logic                sclk,
    input  logic                sclk_pol,
    input  logic [2:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_stop2,
    input  logic                in_valid,
    input  logic [MAX_DATA-1:0] in_data,
    output logic                in_ready,
    output logic                txd
);
    localparam int FRAME_W = MAX_DATA + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic               step;
    logic [FRAME_W-1:0] frame_w;
    logic [LEN_W-1:0]   len_w;

    frame_tx_pace #(.OS_RATE(OS_RATE)) pace_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .os_tick   (os_tick),
        .sclk      (sclk),
        .sclk_pol  (sclk_pol),
        .step_o    (step)
    );

    frame_tx_build #(
        .MIN_DATA (MIN_DATA),
        .MAX_DATA (MAX_DATA),
        .FRAME_W  (FRAME_W),
        .LEN_W    (LEN_W)
    ) build_i (
        .data_i    (in_data),
        .cfg_len   (cfg_len),
        .cfg_par   (cfg_par),
        .cfg_stop2 (cfg_stop2),
        .frame_o   (frame_w),
        .len_o     (len_w)
    );

    frame_tx_shift #(
        .FRAME_W (FRAME_W),
        .LEN_W   (LEN_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .new_frame (frame_w),
        .new_len   (len_w),
        .txd_o     (txd)
    );

endmodule

// File: tb/frame_tx_tb_top.sv
module frame_tx_tb_top;
    typedef int q_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic       os_tick = 1'b0;
    logic       sclk = 1'b0;
    logic       sclk_pol = 1'b0;
    logic [2:0] cfg_len = 3'd0;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = 9'd0;
    logic       in_ready;
    logic       txd;

    int compared = 0;
    int mismatched = 0;
    string phase = "R1 reset";

    always #2 clk = ~clk;

    frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .os_tick(os_tick),
        .sclk(sclk), .sclk_pol(sclk_pol), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .txd(txd)
    );

    // Reference model: each queue entry is bit | (requirement number << 1)
    q_t  line_q;
    q_t  pend_q;
    bit  pend_m = 0;
    bit  busy_m = 0;
    int  cur_m = 3;   // high, tagged R1 idle
    int  tcnt = 0;
    bit  prev_sclk = 0;
    bit  ready_m = 1;
    bit  acc_ev = 0;

    function automatic q_t make_frame(logic [8:0] d, logic [2:0] lc, logic [1:0] pm, logic s2);
        q_t f;
        int n;
        bit p;
        n = (lc > 3'd4) ? 9 : 5 + int'(lc);
        p = 0;
        f.push_back(0 | (2 << 1));                 // R2 start
        for (int i = 0; i < n; i++) begin
            f.push_back(int'(d[i]) | (2 << 1));    // R2 data
            p = p ^ d[i];
        end
        if (pm == 2'b01) f.push_back(int'(p) | (3 << 1));    // R3 even
        if (pm == 2'b10) f.push_back(int'(!p) | (3 << 1));   // R3 odd
        f.push_back(1 | (4 << 1));                 // R4 stop
        if (s2) f.push_back(1 | (4 << 1));
        return f;
    endfunction

    always @(posedge clk) begin
        bit step;
        bit acc;
        bit used;
        q_t nf;
        if (!rst_n) begin
            line_q.delete(); pend_q.delete();
            pend_m = 0; busy_m = 0; cur_m = 3; tcnt = 0;
            prev_sclk = sclk; ready_m = 1; acc_ev = 0;
        end else begin
            if (sync_mode) step = sclk_pol ? (prev_sclk && !sclk) : (!prev_sclk && sclk);
            else           step = os_tick && (tcnt == 15);
            acc  = in_valid && ready_m;
            used = 0;
            if (acc) nf = make_frame(in_data, cfg_len, cfg_par, cfg_stop2);
            if (step) begin
                if (line_q.size() > 0) begin
                    cur_m = line_q.pop_front();
                end else if (pend_m) begin
                    line_q = pend_q; pend_m = 0; busy_m = 1;
                    cur_m = line_q.pop_front();
                end else if (acc) begin
                    line_q = nf; used = 1; busy_m = 1;
                    cur_m = line_q.pop_front();
                end else begin
                    busy_m = 0; cur_m = 3;
                end
            end
            if (acc && !used) begin
                pend_q = nf; pend_m = 1;
            end
            if (!sync_mode && os_tick) tcnt = (tcnt == 15) ? 0 : tcnt + 1;
            prev_sclk = sclk;
            ready_m = !pend_m && (!busy_m || line_q.size() == 0);
            acc_ev = acc;
        end
    end

    task automatic compare();
        compared++;
        if (txd !== cur_m[0]) begin
            mismatched++;
            $display("FAIL R%0d txd (%s) actual=%b expected=%b t=%0t", cur_m >> 1, phase, txd, cur_m[0], $time);
        end
        compared++;
        if (in_ready !== ready_m) begin
            mismatched++;
            $display("FAIL R7 in_ready (%s) actual=%b expected=%b t=%0t", phase, in_ready, ready_m, $time);
        end
    endtask

    // one cycle: check at negedge, then drive new inputs
    task automatic cyc(bit want_valid);
        @(negedge clk);
        compare();
        if (acc_ev || !in_valid) begin
            in_valid = want_valid;
            in_data  = 9'($urandom);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compared++;
        if (txd !== 1'b1 || in_ready !== 1'b1) begin
            mismatched++;
            $display("FAIL R1 reset actual=%b%b expected=11", txd, in_ready);
        end

        // R2 R3 R4 R10: all 30 formats, tick every cycle
        phase = "R2 R3 R4 R10 formats";
        os_tick = 1'b1;
        for (int c = 0; c < 30; c++) begin
            cfg_len   = 3'(c % 5);
            cfg_par   = 2'((c / 5) % 3);
            cfg_stop2 = 1'(c / 15);
            for (int k = 0; k < 456; k++) cyc(1'b1);
        end

        // R5 R8 R9: sparse ticks, format churn, reserved codes, sclk noise
        phase = "R5 R8 R9 async random";
        for (int k = 0; k < 20000; k++) begin
            cfg_len = 3'($urandom); cfg_par = 2'($urandom); cfg_stop2 = 1'($urandom);
            os_tick = 1'($urandom); sclk = 1'($urandom); sclk_pol = 1'($urandom);
            cyc(1'($urandom));
        end

        // R6: serial clock, polarity 0 then 1, ticks ignored
        sync_mode = 1'b1;
        for (int pol = 0; pol < 2; pol++) begin
            phase = (pol == 0) ? "R6 sync rise" : "R6 sync fall";
            sclk_pol = 1'(pol);
            for (int k = 0; k < 8000; k++) begin
                if (k % 2 == 0) sclk = ~sclk;
                cfg_len = 3'($urandom); cfg_par = 2'($urandom); cfg_stop2 = 1'($urandom);
                os_tick = 1'($urandom);
                cyc(($urandom % 4) != 0);
            end
        end

        // R6 R8: fastest serial clock, back-to-back frames
        phase = "R6 R8 sync fast";
        sclk_pol = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            sclk = ~sclk;
            cfg_len = 3'($urandom); cfg_par = 2'($urandom); cfg_stop2 = 1'($urandom);
            cyc(1'b1);
        end

        // R10: return to tick mode from idle
        phase = "R5 R10 async resume";
        sync_mode = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            os_tick = 1'b1;
            cyc((k % 700) < 10);
        end
        summary();
    end

endmodule